// File: doc/BRIEF.md
# Shared-Pin Narrow Peripheral Bus Bridge

This block is the target side of a PCI interface that also serves a small external peripheral bus with an 8-bit data path and a 24-bit address. Slow devices such as boot ROMs or simple I/O chips sit in a 16 MB memory window. The window is chosen by the top address byte. No extra package pins are spent on that bus. While a claimed access is in its data phase, the bridge reuses the PCI address/data lines to carry the peripheral address and data byte. In the same phase it reuses the command/byte-enable lines as read and write strobes. Before and after that phase, every shared line behaves as an ordinary PCI signal.

A single-beat memory read or write whose address hits the window is claimed with medium-speed DEVSEL#. The bridge then presents the latched address for one setup cycle and pulses the selected strobe for a programmable number of cycles, from 1 to 8. It then completes the PCI data phase with TRDY#. A separate active-low chip-enable output frames the whole peripheral access. Read data is captured at the end of the strobe and handed back to the initiator. If the initiator still holds FRAME# when TRDY# is given, the bridge ends the burst attempt with a disconnect-with-data.

Top module: `narrow_bus_bridge`

## Requirements
- R1: While reset is asserted, and in idle afterwards, every output enable (ad_oe_hi, ad_oe_lo, cbe_oe, tgt_oe) is low and xcs_n is high.
- R2: The bridge claims only a memory read (C/BE# command 4'b0110) or a memory write (4'b0111) whose AD[31:24] equals win_base in the address phase. Any other command or upper byte produces no target signal, no chip enable and no pin drive.
- R3: In the first cycle after a claimed address phase, DEVSEL# is driven high. It is driven low from the second cycle after the address phase on (medium decode).
- R4: From the first cycle after the address phase through the TRDY# cycle, AD[31:8] are driven with address bits 23:0 latched in the address phase. The one exception is the TRDY# cycle of a read, where AD[31:8] are driven to zero. C/BE# are driven in the same span. Outside that span, AD and C/BE# are released.
- R5: C/BE#[0] is the active-low read strobe and C/BE#[1] is the active-low write strobe. For wait setting N (wait_cfg, 0 to 7), the strobe of the access direction is low for exactly N+1 cycles, starting in the cycle DEVSEL# first goes low. C/BE#[3:2] stay high, and the two strobes are never low together.
- R6: TRDY# goes low in the cycle right after the last strobe cycle, so it falls N+1 cycles after DEVSEL#. It stays low, with DEVSEL#, until a clock edge on which IRDY# is low.
- R7: For a write, the byte on AD[7:0] in the first cycle after the address phase is driven on AD[7:0] during every strobe cycle and during the TRDY# cycle.
- R8: For a read, AD[7:0] are released during the strobe. The value present on AD[7:0] in the last strobe cycle is driven on AD[7:0] in the TRDY# cycle.
- R9: STOP# is low exactly when TRDY# is low and FRAME# is also low (disconnect with data). Otherwise STOP# is high.
- R10: xcs_n is low from the first cycle after the address phase through the TRDY# cycle, and high at all other times.
- R11: After the completing edge, DEVSEL#, TRDY# and STOP# are driven high for one turnaround cycle with AD and C/BE# released and xcs_n high, and all target signals are released in the cycle after that. A new address phase is recognised only on a FRAME# falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | FRAME# from the initiator |
| irdy_n | input | 1 | IRDY# from the initiator |
| ad_in | input | 32 | Sampled AD lines |
| cbe_in_n | input | 4 | Sampled C/BE# lines |
| win_base | input | 8 | Upper address byte that selects the 16 MB window |
| wait_cfg | input | 3 | Wait setting N; strobe lasts N+1 cycles |
| ad_out | output | 32 | Value driven on AD |
| ad_oe_hi | output | 1 | Drive enable for AD[31:8] |
| ad_oe_lo | output | 1 | Drive enable for AD[7:0] |
| cbe_out_n | output | 4 | Value driven on C/BE# (peripheral strobes) |
| cbe_oe | output | 1 | Drive enable for C/BE# |
| tgt_oe | output | 1 | Drive enable for DEVSEL#, TRDY#, STOP# |
| devsel_n | output | 1 | DEVSEL# |
| trdy_n | output | 1 | TRDY# |
| stop_n | output | 1 | STOP# |
| xcs_n | output | 1 | Peripheral chip enable, active low |

## Verification
Two functions can land in the same cycle: completing the data phase with TRDY# and disconnecting with STOP#. The bench provokes this by keeping FRAME# low through a read with the longest wait setting. It checks that STOP# falls in the very cycle TRDY# falls, and that the returned byte is the one sampled on the last strobe cycle. The same accesses without FRAME# held low must show STOP# high while TRDY# is low. In another case, IRDY# is held high in the TRDY# cycle, which shows that TRDY# and the data stay in place until the handshake completes.

// File: rtl/nbb_pkg.sv
package nbb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_XFER,
        ST_DONE,
        ST_TURN
    } nbb_state_e;

    localparam logic [3:0] CMD_MEMRD = 4'b0110;
    localparam logic [3:0] CMD_MEMWR = 4'b0111;
endpackage

// File: rtl/nbb_decode.sv
module nbb_decode #(
    parameter int AD_W  = 32,
    parameter int WIN_W = 8
) (
    input  logic [AD_W-1:0]  ad,
    input  logic [3:0]       cmd_n,
    input  logic [WIN_W-1:0] win_base,
    output logic             hit,
    output logic             is_wr
);
    import nbb_pkg::*;

    logic is_mem;

    always_comb begin
        is_mem = (cmd_n == CMD_MEMRD) || (cmd_n == CMD_MEMWR);
        hit    = is_mem && (ad[AD_W-1 -: WIN_W] == win_base);
        is_wr  = (cmd_n == CMD_MEMWR);
    end
endmodule

// File: rtl/nbb_wait.sv
module nbb_wait #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] cfg,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = cfg;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    p_count_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(!load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/narrow_bus_bridge.sv
module narrow_bus_bridge #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_n,
    input  logic                         irdy_n,
    input  logic [ADDR_W+DATA_W-1:0]     ad_in,
    input  logic [3:0]                   cbe_in_n,
    input  logic [ADDR_W+DATA_W-25:0]    win_base,
    input  logic [WAIT_W-1:0]            wait_cfg,
    output logic [ADDR_W+DATA_W-1:0]     ad_out,
    output logic                         ad_oe_hi,
    output logic                         ad_oe_lo,
    output logic [3:0]                   cbe_out_n,
    output logic                         cbe_oe,
    output logic                         tgt_oe,
    output logic                         devsel_n,
    output logic                         trdy_n,
    output logic                         stop_n,
    output logic                         xcs_n
);
    import nbb_pkg::*;

    localparam int AD_W  = ADDR_W + DATA_W;
    localparam int WIN_W = AD_W - ADDR_W;

    typedef struct packed {
        nbb_state_e          state;
        logic                frame_q;
        logic                is_wr;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wbyte;
        logic [DATA_W-1:0]   rbyte;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit, dec_wr, expired, addr_phase;

    nbb_decode #(.AD_W(AD_W), .WIN_W(WIN_W)) u_dec (
        .ad       (ad_in),
        .cmd_n    (cbe_in_n),
        .win_base (win_base),
        .hit      (hit),
        .is_wr    (dec_wr)
    );

    nbb_wait #(.W(WAIT_W)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (r_q.state == ST_SETUP),
        .cfg     (wait_cfg),
        .expired (expired)
    );

    assign addr_phase = !frame_n && r_q.frame_q;

    // next-state process
    always_comb begin
        r_d         = r_q;
        r_d.frame_q = frame_n;
        unique case (r_q.state)
            ST_IDLE: if (addr_phase && hit) begin
                r_d.state = ST_SETUP;
                r_d.addr  = ad_in[ADDR_W-1:0];
                r_d.is_wr = dec_wr;
            end
            ST_SETUP: begin
                if (r_q.is_wr) r_d.wbyte = ad_in[DATA_W-1:0];
                r_d.state = ST_XFER;
            end
            ST_XFER: begin
                if (!r_q.is_wr) r_d.rbyte = ad_in[DATA_W-1:0];
                if (expired) r_d.state = ST_DONE;
            end
            ST_DONE: if (!irdy_n) r_d.state = ST_TURN;
            ST_TURN: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.state   <= ST_IDLE;
            r_q.frame_q <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    // pin function selection
    always_comb begin
        ad_out    = '0;
        ad_oe_hi  = 1'b0;
        ad_oe_lo  = 1'b0;
        cbe_out_n = 4'hF;
        cbe_oe    = 1'b0;
        tgt_oe    = 1'b0;
        devsel_n  = 1'b1;
        trdy_n    = 1'b1;
        stop_n    = 1'b1;
        xcs_n     = 1'b1;
        unique case (r_q.state)
            ST_SETUP: begin
                tgt_oe   = 1'b1;
                xcs_n    = 1'b0;
                cbe_oe   = 1'b1;
                ad_oe_hi = 1'b1;
                ad_out[AD_W-1:DATA_W] = r_q.addr;
            end
            ST_XFER: begin
                tgt_oe   = 1'b1;
                devsel_n = 1'b0;
                xcs_n    = 1'b0;
                cbe_oe   = 1'b1;
                ad_oe_hi = 1'b1;
                ad_out[AD_W-1:DATA_W] = r_q.addr;
                if (r_q.is_wr) begin
                    cbe_out_n = 4'b1101;
                    ad_oe_lo  = 1'b1;
                    ad_out[DATA_W-1:0] = r_q.wbyte;
                end else begin
                    cbe_out_n = 4'b1110;
                end
            end
            ST_DONE: begin
                tgt_oe   = 1'b1;
                devsel_n = 1'b0;
                trdy_n   = 1'b0;
                stop_n   = frame_n;
                xcs_n    = 1'b0;
                cbe_oe   = 1'b1;
                ad_oe_hi = 1'b1;
                ad_oe_lo = 1'b1;
                if (r_q.is_wr)
                    ad_out = {r_q.addr, r_q.wbyte};
                else
                    ad_out[DATA_W-1:0] = r_q.rbyte;
            end
            ST_TURN: tgt_oe = 1'b1;
            default: ;
        endcase
    end

    p_trdy_with_devsel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> (!devsel_n && tgt_oe));
    p_devsel_medium_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> !$past(frame_n, 2));
    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cbe_oe |-> ($countones(~cbe_out_n[1:0]) <= 1 && cbe_out_n[3:2] == 2'b11));
    p_stop_needs_trdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n |-> !trdy_n);
    p_pins_under_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe_hi || ad_oe_lo || cbe_oe) |-> !xcs_n);
    p_trdy_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trdy_n) |-> $past(cbe_out_n[1:0] != 2'b11));
    p_turnaround_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trdy_n) |-> (tgt_oe && devsel_n && stop_n && xcs_n));
endmodule

// File: tb/sim_narrow_bus_bridge.sv
module sim_narrow_bus_bridge;
    localparam logic [7:0] WIN = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_in_n = 4'hF;
    logic [7:0]  win_base = WIN;
    logic [2:0]  wait_cfg = '0;
    logic [31:0] ad_out;
    logic        ad_oe_hi, ad_oe_lo, cbe_oe, tgt_oe;
    logic [3:0]  cbe_out_n;
    logic        devsel_n, trdy_n, stop_n, xcs_n;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    narrow_bus_bridge u0 (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .ad_in(ad_in), .cbe_in_n(cbe_in_n), .win_base(win_base), .wait_cfg(wait_cfg),
        .ad_out(ad_out), .ad_oe_hi(ad_oe_hi), .ad_oe_lo(ad_oe_lo),
        .cbe_out_n(cbe_out_n), .cbe_oe(cbe_oe), .tgt_oe(tgt_oe),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .xcs_n(xcs_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, {28'd0, ad_oe_hi, ad_oe_lo, cbe_oe, tgt_oe}, 32'd0);
        chk(req, {31'd0, xcs_n}, 32'd1);
    endtask

    // one claimed access: n = wait setting, disc = keep FRAME# low, hold = extra IRDY# wait
    task automatic access(input bit wr, input logic [23:0] a, input logic [7:0] wb,
                          input int n, input bit disc, input int hold);
        logic [7:0] rd;
        @(negedge clk);
        frame_n  = 1'b0;
        ad_in    = {WIN, a};
        cbe_in_n = wr ? 4'b0111 : 4'b0110;
        wait_cfg = 3'(n);
        @(negedge clk);
        chk("R3 setup devsel high", {30'd0, tgt_oe, devsel_n}, 32'd3);
        chk("R4 setup address", {7'd0, ad_oe_hi, ad_out[31:8]}, {8'h01, a});
        chk("R4 setup cbe", {27'd0, cbe_oe, cbe_out_n}, 32'h1F);
        chk("R10 setup cs", {31'd0, xcs_n}, 32'd0);
        frame_n  = disc ? 1'b0 : 1'b1;
        irdy_n   = 1'b0;
        ad_in    = {24'h0, wb};
        cbe_in_n = 4'b1110;
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            chk("R3 devsel low", {31'd0, devsel_n}, 32'd0);
            chk("R6 trdy waits", {31'd0, trdy_n}, 32'd1);
            chk("R5 strobe", {28'd0, cbe_out_n}, wr ? 32'hD : 32'hE);
            chk("R4 strobe address", {7'd0, ad_oe_hi, ad_out[31:8]}, {8'h01, a});
            chk("R10 strobe cs", {31'd0, xcs_n}, 32'd0);
            if (wr) chk("R7 write byte", {23'd0, ad_oe_lo, ad_out[7:0]}, {24'h1, wb});
            else    chk("R8 released", {31'd0, ad_oe_lo}, 32'd0);
            ad_in[7:0] = wb ^ 8'(i);
            if (i == n && hold > 0) irdy_n = 1'b1;
        end
        rd = wb ^ 8'(n);
        for (int h = 0; h <= hold; h++) begin
            @(negedge clk);
            chk("R6 trdy", {30'd0, trdy_n, devsel_n}, 32'd0);
            chk("R9 stop", {31'd0, stop_n}, disc ? 32'd0 : 32'd1);
            chk("R5 strobes off", {28'd0, cbe_out_n}, 32'hF);
            chk("R10 trdy cs", {31'd0, xcs_n}, 32'd0);
            if (wr) chk("R7 write data", ad_out, {a, wb});
            else    chk("R8 read data", ad_out, {24'h0, rd});
            chk("R4 drive", {30'd0, ad_oe_hi, ad_oe_lo}, 32'd3);
            if (h == hold) irdy_n = 1'b0;
        end
        frame_n = 1'b1;
        @(negedge clk);
        chk("R11 turn", {27'd0, tgt_oe, devsel_n, trdy_n, stop_n, xcs_n}, 32'h1F);
        chk("R11 released", {29'd0, ad_oe_hi, ad_oe_lo, cbe_oe}, 32'd0);
        irdy_n = 1'b1;
        @(negedge clk);
        chk_idle("R11 idle");
    endtask

    task automatic ignored(input logic [31:0] adr, input logic [3:0] cmd);
        @(negedge clk);
        frame_n  = 1'b0;
        ad_in    = adr;
        cbe_in_n = cmd;
        @(negedge clk);
        frame_n = 1'b1;
        irdy_n  = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk_idle("R2 not claimed");
            @(negedge clk);
        end
        irdy_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after reset");
        access(1'b1, 24'h123456, 8'h3C, 3, 1'b0, 0);
        access(1'b0, 24'hFEDCBA, 8'h81, 0, 1'b0, 0);
        access(1'b0, 24'h000001, 8'h5A, 7, 1'b1, 0);   // disconnect and TRDY together (R9)
        access(1'b1, 24'hFFFFFF, 8'hE7, 0, 1'b1, 2);   // IRDY# late (R6)
        ignored({8'hA4, 24'h123456}, 4'b0110);         // R2 other window
        ignored({WIN, 24'h123456}, 4'b0011);           // R2 I/O write
        access(1'b0, 24'h800000, 8'h00, 5, 1'b0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule